// File: doc/BRIEF.md
# Register-driven JTAG bit-bang port

This block gives host software direct, one-clock-at-a-time control of a JTAG chain through a single 32-bit register. It is meant for in-field reprogramming of a configuration device over a host bus. Software writes a word to the register. The two lowest bits of that word become TDI and TMS, and the block then produces exactly one TCK pulse. Software reads the register to see the TDO line.

The read word has two parts. The top bit is the TDO level sampled in the same cycle as the read strobe. The lower 31 bits hold earlier TDO samples. On every TCK rising edge this history shifts one place toward bit 0, and the TDO sample taken at that edge enters bit 30. After 31 pulses, software can therefore recover a full shifted-out word with one read.

The pulse timing is fixed by parameters. TCK stays high for `HI_CLKS` system clocks and is then held low for `LO_CLKS` system clocks before another write is taken. TMS and TDI change only when a write is accepted, so they are stable around both edges of TCK. A write that arrives while a pulse is still in progress is dropped.

Top module: `jtag_bitbang_port`

## Requirements
- R1: A write strobe sampled at clock edge k while the port is idle produces exactly one TCK pulse. TCK rises at edge k+1 and falls at edge k+1+HI_CLKS.
- R2: On an accepted write, data bit 0 drives TDI and data bit 1 drives TMS, both from edge k. No other write data bit has any effect on any output.
- R3: TMS and TDI change only at the edge that accepts a write. They are therefore stable for at least one clock before each TCK rise and for at least LO_CLKS clocks after each TCK fall.
- R4: TCK is high for HI_CLKS clocks. After it falls, the port accepts no write until LO_CLKS+1 edges have passed. The next write can be accepted at edge k+2+HI_CLKS+LO_CLKS at the earliest. Both parameters must be at least 2.
- R5: A write strobe sampled at any edge from k+1 through k+1+HI_CLKS+LO_CLKS is ignored. It produces no TCK pulse and no change on TMS or TDI.
- R6: At each TCK rising edge, the 31-bit TDO history shifts right by one place. The oldest sample in bit 0 is dropped, and the TDO level at that edge enters bit 30. The history changes at no other time.
- R7: A read strobe sampled at edge r loads the read output at edge r. The top bit receives the TDO level at edge r, and bits 30..0 receive the history as it stood before that edge. The read output holds its value when there is no read strobe.
- R8: After reset, TCK is 0, TMS is 1, TDI is 0, the TDO history is all zeros, the read output is zero and the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data: bit 0 is TDI, bit 1 is TMS |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Read word: live TDO in bit 31, TDO history in bits 30..0 |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG test mode select |
| tdi_o | output | 1 | JTAG test data to the chain |
| tdo_i | input | 1 | JTAG test data from the chain |

## Verification
The timing of each result is fixed relative to the accepting edge k:
- TMS and TDI are due at edge k.
- TCK rises, and the history shift happens, at edge k+1.
- TCK falls at edge k+1+HI_CLKS.
- The port accepts a new write again from edge k+2+HI_CLKS+LO_CLKS.
- A read word is due at the edge that samples the read strobe.

The bench's reference model advances on the same rising edges, counting cycles from each accepted write. The bench compares every output against the model on the falling edge that follows, where nothing is changing. Stimulus also changes only on falling edges. Back-to-back write strobes are used to hit the ignored window at every possible offset.

// File: rtl/jtag_bitbang_port.sv
module jtag_bitbang_port #(
  parameter int DW      = 32,
  parameter int HI_CLKS = 3,
  parameter int LO_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          tck_o,
  output logic          tms_o,
  output logic          tdi_o,
  input  logic          tdo_i
);

  localparam int HW    = DW - 1;
  localparam int MAXPH = (HI_CLKS > LO_CLKS) ? HI_CLKS : LO_CLKS;
  localparam int CW    = $clog2(MAXPH + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_HIGH, S_LOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hist;
  logic          idle;

  assign idle = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      tck_o     <= 1'b0;
      tms_o     <= 1'b1;
      tdi_o     <= 1'b0;
      hist      <= '0;
      rd_data_o <= '0;
    end else begin
      if (rd_en_i) rd_data_o <= {tdo_i, hist};
      unique case (st)
        S_IDLE: if (wr_en_i) begin
          tdi_o <= wr_data_i[0];
          tms_o <= wr_data_i[1];
          st    <= S_SETUP;
        end
        S_SETUP: begin
          tck_o <= 1'b1;
          hist  <= {tdo_i, hist[HW-1:1]};
          cnt   <= CW'(HI_CLKS - 1);
          st    <= S_HIGH;
        end
        S_HIGH: if (cnt == '0) begin
          tck_o <= 1'b0;
          cnt   <= CW'(LO_CLKS - 1);
          st    <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idle) |=> !tck_o ##1 tck_o); // R1
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(tms_o) && $stable(tdi_o))); // R3
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !idle) |=> ($stable(tms_o) && $stable(tdi_o))); // R5
  AST_HIST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_SETUP) |=> $stable(hist)); // R6
  AST_RD_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> (rd_data_o[DW-1] == $past(tdo_i))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R7

endmodule

// File: tb/test_jtag_bitbang_port.sv
module test_jtag_bitbang_port;
  localparam int HI = 3;
  localparam int LO = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        tdo = 1'b0;
  logic [31:0] rd_data;
  logic        tck, tms, tdi;

  always #2.5 clk = ~clk;

  jtag_bitbang_port #(.DW(32), .HI_CLKS(HI), .LO_CLKS(LO)) i_jtag_bitbang_port (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .tck_o(tck), .tms_o(tms),
    .tdi_o(tdi), .tdo_i(tdo));

  int total = 0;
  int bad = 0;

  // behavioural reference model
  int          m_t;
  logic        m_tck, m_tms, m_tdi;
  logic [30:0] m_hist;
  logic [31:0] m_rd;
  int          m_accepts;
  int          seen_rises;
  logic        prev_tck;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = -1; m_tck = 0; m_tms = 1; m_tdi = 0; m_hist = '0; m_rd = '0;
      m_accepts = 0;
    end else begin
      if (rd_en) m_rd = {tdo, m_hist};
      if (m_t < 0) begin
        if (wr_en) begin
          m_t = 0; m_tdi = wr_data[0]; m_tms = wr_data[1]; m_accepts++;
        end
      end else begin
        m_t++;
        if (m_t == 1) begin m_tck = 1; m_hist = {tdo, m_hist[30:1]}; end
        if (m_t == 1 + HI) m_tck = 0;
        if (m_t == 1 + HI + LO) m_t = -1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R4 tck", {31'd0, tck}, {31'd0, m_tck});
      chk("R2/R3/R5 tms", {31'd0, tms}, {31'd0, m_tms});
      chk("R2/R3/R5 tdi", {31'd0, tdi}, {31'd0, m_tdi});
      chk("R6/R7 rd_data", rd_data, m_rd);
      if (tck && !prev_tck) seen_rises++;
      prev_tck = tck;
    end else begin
      seen_rises = 0; prev_tck = 0;
    end
  end

  task automatic cyc(input logic w, input logic [31:0] d, input logic r, input logic t);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; tdo = t;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 tck", {31'd0, tck}, 32'd0);
    chk("R8 tms", {31'd0, tms}, 32'd1);
    chk("R8 tdi", {31'd0, tdi}, 32'd0);
    chk("R8 rd_data", rd_data, 32'd0);
    rst_n = 1'b1;
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);
    chk("R8 history zero", rd_data, 32'h8000_0000);

    // R2: TMS=1, TDI=0
    cyc(1, 32'h0000_0002, 0, 1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 1);
    chk("R2 tms set", {31'd0, tms}, 32'd1);
    // R2: upper bits ignored
    cyc(1, 32'hFFFF_FFFC, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R2 other bits ignored tms", {31'd0, tms}, 32'd0);
    chk("R2 other bits ignored tdi", {31'd0, tdi}, 32'd0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0);

    // R5: writes during a pulse dropped
    cyc(1, 32'h1, 0, 1);
    for (int i = 0; i < HI + LO + 1; i++) cyc(1, 32'h2, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R5 tms unchanged by busy write", {31'd0, tms}, 32'd0);
    chk("R5 tdi unchanged by busy write", {31'd0, tdi}, 32'd1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);

    // R6/R7: walk a TDO pattern through the history
    for (int n = 0; n < 34; n++) begin
      cyc(1, n, 0, n[0] ^ n[2]);
      for (int i = 0; i < HI + LO + 1; i++) cyc(0, 0, (i == 2), n[1]);
    end
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R6 history after walk", rd_data, m_rd);

    // back-to-back strobes: hit every busy offset
    for (int n = 0; n < 60; n++) cyc(1, 32'(n * 5), n[0], n[1] ^ n[3]);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 1);

    chk("R1/R5 one pulse per accepted write", 32'(seen_rises), 32'(m_accepts));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule